// File: doc/BRIEF.md
# Receive Queue with Per-Entry Error Tags

This block is the receive-side character queue of a UART. Every character that arrives from the serial receiver is stored with three error tags (parity, framing, overrun), and the tags stay attached to their character until the character is read out. The queue is twelve entries deep. A CPU reads it through a register-style port: the character at the head and its three tags are always visible, and a pop strobe advances the queue. A DMA request line asks an external engine for a four-word burst once enough characters are stored.

Errors near the read end get special handling. If any of the four entries closest to the head carries a tag, a sticky error interrupt is raised. While that interrupt is set, or while a tagged entry is still inside the four-entry head window, DMA requests are held off. This lets software drain the suspect characters one at a time and check the head tags before each pop. The interrupt is cleared by a write-one-to-clear strobe from the CPU. A clear succeeds only if the head window holds no tagged entry.

Top module: `rx_tagged_fifo`

## Requirements
- R1: After reset the level is 0, `rdData` and all three head flags are 0, and `errIrq` and `dmaReq` are 0.
- R2: Characters leave the queue in the order they were accepted. `rxLevel` goes up by one for each accepted write and down by one for each pop of a non-empty queue. Both changes take effect on the clock edge that samples the strobe.
- R3: `rdData`, `headParErr`, `headFrmErr` and `headOvrErr` always show the data and tags of the entry at the head. They are all 0 while the queue is empty.
- R4: On the clock edge after any of the first four entries from the head (only entries that are present count) carries a tag, `errIrq` becomes 1. A tagged entry at position five or deeper does not set it.
- R5: `errIrq` stays 1 until an `irqClr` pulse arrives in a cycle where the head window holds no tagged entry. A pulse while a tagged entry is in the window leaves it at 1.
- R6: `dmaReq` is 1 exactly when all of these hold:
  - `rxLevel` is at least `REQ_LEVEL` (default 8, allowed range 5 to 8, never below the burst size of 4);
  - `errIrq` is 0;
  - no tagged entry is in the head window.
- R7: The queue holds 12 entries. A write to a full queue with no pop in the same cycle drops the incoming character, keeps the level at 12, and sets the overrun tag of the newest stored entry.
- R8: A pop on an empty queue has no effect: the level stays 0 and `rdData` stays 0.
- R9: A write and a pop in the same cycle on a non-empty queue leave the level unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Receiver delivers a character this cycle |
| wrData | input | 8 | Received character |
| wrParErr | input | 1 | Parity error tag of the character |
| wrFrmErr | input | 1 | Framing error tag of the character |
| wrOvrErr | input | 1 | Overrun tag of the character |
| rdPop | input | 1 | CPU removes the head entry |
| irqClr | input | 1 | CPU write-one-to-clear of the error interrupt |
| rdData | output | 8 | Character at the head |
| headParErr | output | 1 | Parity tag of the head entry |
| headFrmErr | output | 1 | Framing tag of the head entry |
| headOvrErr | output | 1 | Overrun tag of the head entry |
| errIrq | output | 1 | Sticky error interrupt status |
| dmaReq | output | 1 | Burst service request to the DMA engine |
| rxLevel | output | 4 | Number of stored entries |

## Verification
The assertions assume that the strobes are synchronous, single-cycle levels sampled at the clock edge. They also assume that `REQ_LEVEL` is never below the burst size, so that a request always covers a full burst. The stimulus changes inputs only on the falling edge and holds each strobe high for exactly one cycle. It overfills the queue only through the dedicated full-queue test, and it issues `irqClr` only as an isolated one-cycle pulse, both with a tagged entry inside the head window and with none there.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DATA_W = 8;
  localparam int RXQ_IDX_W  = 8;

  typedef struct packed {
    logic                  ovr;
    logic                  frm;
    logic                  par;
    logic [RXQ_DATA_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic                 push;
    logic                 pop;
    logic                 markOvr;
    logic [RXQ_IDX_W-1:0] wrIdx;
    logic [RXQ_IDX_W-1:0] rdIdx;
    logic [RXQ_IDX_W-1:0] lastIdx;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 12,
  parameter int REQ_LEVEL = 8,
  parameter int BURST     = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             rdPop,
  input  logic             irqClr,
  input  logic             winErr,
  output rxqStrobe_t       strb,
  output logic [CNT_W-1:0] level,
  output logic             errIrq,
  output logic             dmaReq
);
  logic [RXQ_IDX_W-1:0] wrPtr, rdPtr;
  logic full, empty, doPush, doPop, markOvr;

  function automatic logic [RXQ_IDX_W-1:0] bumpIdx(input logic [RXQ_IDX_W-1:0] idx);
    return (idx == RXQ_IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  assign full    = (level == CNT_W'(DEPTH));
  assign empty   = (level == '0);
  assign doPop   = rdPop && !empty;
  assign doPush  = wrValid && (!full || doPop);
  assign markOvr = wrValid && full && !doPop;

  always_comb begin
    strb.push    = doPush;
    strb.pop     = doPop;
    strb.markOvr = markOvr;
    strb.wrIdx   = wrPtr;
    strb.rdIdx   = rdPtr;
    strb.lastIdx = (wrPtr == '0) ? RXQ_IDX_W'(DEPTH - 1) : wrPtr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      errIrq <= 1'b0;
    end else begin
      if (doPush) wrPtr <= bumpIdx(wrPtr);
      if (doPop)  rdPtr <= bumpIdx(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      errIrq <= winErr | (errIrq & ~irqClr);
    end
  end

  assign dmaReq = (level >= CNT_W'(REQ_LEVEL)) && (level >= CNT_W'(BURST))
                  && !errIrq && !winErr;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 12,
  parameter int HEAD_WIN = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobe_t       strb,
  input  rxEntry_t         wrEntry,
  input  logic [CNT_W-1:0] level,
  output rxEntry_t         headEntry,
  output logic             winErr
);
  rxEntry_t mem [DEPTH];
  logic [HEAD_WIN-1:0] slotErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.push) mem[strb.wrIdx] <= wrEntry;
      if (strb.markOvr) mem[strb.lastIdx].ovr <= 1'b1;
    end
  end

  assign headEntry = (level != '0) ? mem[strb.rdIdx] : '0;

  for (genvar g = 0; g < HEAD_WIN; g++) begin : gSlot
    logic [RXQ_IDX_W:0] sum;
    logic [RXQ_IDX_W-1:0] idx;
    assign sum = {1'b0, strb.rdIdx} + (RXQ_IDX_W + 1)'(g);
    assign idx = (sum >= (RXQ_IDX_W + 1)'(DEPTH)) ? RXQ_IDX_W'(sum - (RXQ_IDX_W + 1)'(DEPTH))
                                                   : sum[RXQ_IDX_W-1:0];
    assign slotErr[g] = (level > CNT_W'(g)) && (mem[idx].par | mem[idx].frm | mem[idx].ovr);
  end

  assign winErr = |slotErr;
endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 12,
  parameter int REQ_LEVEL = 8,
  parameter int BURST     = 4,
  parameter int HEAD_WIN  = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  input  logic [RXQ_DATA_W-1:0] wrData,
  input  logic                  wrParErr,
  input  logic                  wrFrmErr,
  input  logic                  wrOvrErr,
  input  logic                  rdPop,
  input  logic                  irqClr,
  output logic [RXQ_DATA_W-1:0] rdData,
  output logic                  headParErr,
  output logic                  headFrmErr,
  output logic                  headOvrErr,
  output logic                  errIrq,
  output logic                  dmaReq,
  output logic [CNT_W-1:0]      rxLevel
);
  rxqStrobe_t strb;
  rxEntry_t   wrEntry, headEntry;
  logic       winErr;

  assign wrEntry = '{ovr: wrOvrErr, frm: wrFrmErr, par: wrParErr, data: wrData};

  rxq_ctrl #(.DEPTH(DEPTH), .REQ_LEVEL(REQ_LEVEL), .BURST(BURST)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdPop(rdPop), .irqClr(irqClr),
    .winErr(winErr), .strb(strb), .level(rxLevel), .errIrq(errIrq), .dmaReq(dmaReq)
  );

  rxq_store #(.DEPTH(DEPTH), .HEAD_WIN(HEAD_WIN)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEntry(wrEntry), .level(rxLevel),
    .headEntry(headEntry), .winErr(winErr)
  );

  assign rdData     = headEntry.data;
  assign headParErr = headEntry.par;
  assign headFrmErr = headEntry.frm;
  assign headOvrErr = headEntry.ovr;
endmodule

// File: rtl/rx_tagged_fifo_chk.sv
module rx_tagged_fifo_chk #(
  parameter int DEPTH = 12,
  parameter int BURST = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic             rdPop,
  input logic             irqClr,
  input logic [7:0]       rdData,
  input logic             headParErr,
  input logic             headFrmErr,
  input logic             headOvrErr,
  input logic             errIrq,
  input logic             dmaReq,
  input logic [CNT_W-1:0] rxLevel
);
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel <= CNT_W'(DEPTH));

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == CNT_W'(DEPTH) && wrValid && !rdPop) |=> rxLevel == CNT_W'(DEPTH));

  assert_dma_burst_R6: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> rxLevel >= CNT_W'(BURST));

  assert_dma_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> !dmaReq);

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq && !irqClr) |=> errIrq);

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == '0 && rdPop && !wrValid) |=> rxLevel == '0);

  assert_empty_head_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == '0) |-> (rdData == '0 && !headParErr && !headFrmErr && !headOvrErr));

  assert_push_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !rdPop && rxLevel < CNT_W'(DEPTH)) |=> rxLevel == $past(rxLevel) + 1'b1);

  assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && rdPop && rxLevel != '0) |=> $stable(rxLevel));
endmodule

bind rx_tagged_fifo rx_tagged_fifo_chk #(.DEPTH(DEPTH), .BURST(BURST)) u_chk (.*);

// File: tb/rx_tagged_fifo_tb.sv
module rx_tagged_fifo_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 0, wrParErr = 0, wrFrmErr = 0, wrOvrErr = 0, rdPop = 0, irqClr = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic headParErr, headFrmErr, headOvrErr, errIrq, dmaReq;
  logic [3:0] rxLevel;

  int checks = 0;
  int errors = 0;
  logic [10:0] sb[$];

  always #2 clk = ~clk;

  rx_tagged_fifo u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushChar(input logic [7:0] d, input logic p, input logic f, input logic o);
    sb.push_back({o, f, p, d});
    wrValid = 1; wrData = d; wrParErr = p; wrFrmErr = f; wrOvrErr = o;
    @(negedge clk);
    wrValid = 0; wrParErr = 0; wrFrmErr = 0; wrOvrErr = 0;
  endtask

  // monitor: compare the head against the scoreboard, then pop it
  task automatic popCmp(input string tag);
    logic [10:0] e;
    e = sb.pop_front();
    chk({tag, " data"}, rdData, e[7:0]);
    chk({tag, " par"}, headParErr, e[8]);
    chk({tag, " frm"}, headFrmErr, e[9]);
    chk({tag, " ovr"}, headOvrErr, e[10]);
    rdPop = 1;
    @(negedge clk);
    rdPop = 0;
  endtask

  task automatic clearIrq();
    irqClr = 1;
    @(negedge clk);
    irqClr = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    // R1 reset state
    chk("R1 level", rxLevel, 0);
    chk("R1 data", rdData, 0);
    chk("R1 irq", errIrq, 0);
    chk("R1 dma", dmaReq, 0);

    // R2/R3 basic order
    pushChar(8'h11, 0, 0, 0);
    pushChar(8'h22, 0, 0, 0);
    pushChar(8'h33, 0, 0, 0);
    chk("R2 level", rxLevel, 3);
    for (int i = 0; i < 3; i++) popCmp("R2 order");
    chk("R2 level drain", rxLevel, 0);

    // R8 pop on empty
    rdPop = 1; @(negedge clk); rdPop = 0;
    chk("R8 level", rxLevel, 0);
    chk("R8 data", rdData, 0);
    chk("R3 empty par", headParErr, 0);

    // R6 threshold
    for (int i = 0; i < 7; i++) pushChar(8'h40 + 8'(i), 0, 0, 0);
    chk("R6 below threshold", dmaReq, 0);
    pushChar(8'h47, 0, 0, 0);
    chk("R6 at threshold", dmaReq, 1);
    popCmp("R6 pop");
    chk("R6 after pop", dmaReq, 0);
    while (sb.size() > 0) popCmp("R2 drain");

    // R4 tagged entry at position five does not raise irq
    for (int i = 0; i < 4; i++) pushChar(8'h50 + 8'(i), 0, 0, 0);
    pushChar(8'h5A, 1, 0, 0);
    idle(1);
    chk("R4 deep tag ignored", errIrq, 0);
    popCmp("R4 pop");
    chk("R4 window err blocks dma", dmaReq, 0);
    idle(1);
    chk("R4 irq raised", errIrq, 1);
    clearIrq();
    chk("R5 clear refused", errIrq, 1);
    for (int i = 0; i < 3; i++) popCmp("R4 pop");
    popCmp("R3 parity head");
    idle(1);
    chk("R5 sticky", errIrq, 1);
    clearIrq();
    chk("R5 cleared", errIrq, 0);

    // R6 dma held off by a tagged entry in the window
    pushChar(8'h60, 0, 0, 0);
    pushChar(8'h61, 0, 1, 0);
    for (int i = 0; i < 6; i++) pushChar(8'h62 + 8'(i), 0, 0, 0);
    chk("R6 level 8", rxLevel, 8);
    chk("R6 dma blocked", dmaReq, 0);
    chk("R4 irq frm", errIrq, 1);
    popCmp("R6 pop");
    popCmp("R3 framing head");
    clearIrq();
    chk("R5 cleared again", errIrq, 0);
    while (sb.size() > 0) popCmp("R2 drain");

    // R7 full queue
    for (int i = 0; i < 12; i++) pushChar(8'h70 + 8'(i), 0, 0, 0);
    chk("R7 level full", rxLevel, 12);
    chk("R6 dma when full", dmaReq, 1);
    wrValid = 1; wrData = 8'hEE; @(negedge clk); wrValid = 0;
    sb[11][10] = 1'b1;
    chk("R7 level stays", rxLevel, 12);
    chk("R7 head untouched", headOvrErr, 0);
    while (sb.size() > 0) popCmp("R7 drain");
    chk("R7 empty after drain", rxLevel, 0);
    idle(1);
    clearIrq();
    chk("R5 final clear", errIrq, 0);

    // R9 simultaneous write and pop
    pushChar(8'hA0, 0, 0, 0);
    pushChar(8'hA1, 0, 0, 0);
    sb.push_back({3'b000, 8'hA2});
    chk("R9 head data", rdData, 8'hA0);
    void'(sb.pop_front());
    wrValid = 1; wrData = 8'hA2; rdPop = 1;
    @(negedge clk);
    wrValid = 0; rdPop = 0;
    chk("R9 level kept", rxLevel, 2);
    popCmp("R9 order");
    popCmp("R9 order");
    chk("R9 empty", rxLevel, 0);

    summary();
  end
endmodule